// File: doc/BRIEF.md
# Cascaded Interrupt Priority Encoder

The block gathers interrupt requests from three tiers (critical, main and peripheral) and condenses them into one read-only status word. The processor reads that word to learn which tiers hold a request and which source in each tier has priority. Each tier has its own valid bit and code field. Software examines the critical field first, then the main field, then the peripheral field.

Two codes in the upper tiers do not stand for a source of their own. They are cascade slots that point into the peripheral tier. Critical code 2 is raised when an unmasked peripheral from a fixed high-priority set is pending. Main code 4 is raised when an unmasked peripheral outside that set is pending. Peripheral source 0 is the summary request of a DMA engine. Critical requests are pulses, and the block holds them until software acknowledges them through the status address. Main and peripheral requests are levels, and the requesting logic clears them. Main and peripheral masks are written over a simple register write port. In both masks a set bit disables the source.

Top module: `irq_cascade_enc`

## Requirements
- R1: After reset, status_o and irq_o are 0, the main mask holds 0x00010FFF and the peripheral mask holds 0x7FFFFC00.
- R2: Status layout: bit 10 is critical valid, bits 9:8 the critical code; bit 21 is main valid, bits 20:16 the main code; bit 29 is peripheral valid, bits 28:24 the peripheral code. All other bits are 0, and a field whose valid bit is clear reads code 0.
- R3: Within each tier the lowest-numbered pending, unmasked source is reported.
- R4: A write to address 1 loads the main mask. Bit 16−n disables main source n, and data bits 31:17 are ignored. Main sources 0..3 and 5..16 come from main_pend_i bits 0..3 and 4..15. Writes to address 3 change nothing.
- R5: A write to address 2 loads the peripheral mask, and bit 31−n disables peripheral source n. Source 0 is dma_pend_i, and sources 1..31 are peri_pend_i bits 0..30.
- R6: A one-cycle pulse on crit_req_i bits 0, 1 and 2 sets a held request for critical sources 0, 1 and 3 respectively.
- R7: Critical code 2 is pending whenever an unmasked peripheral source numbered 4 to 7 (the high-priority set) is pending. While any such source is pending, the peripheral field reports the lowest one of that set.
- R8: Main code 4 is pending whenever an unmasked peripheral outside the high-priority set is pending, subject to main mask bit 12. When no high-priority peripheral is pending, the peripheral field reports the lowest unmasked pending peripheral.
- R9: A write to address 0 with data bit 10 set clears the held critical request whose code is currently reported. It has no effect when bit 10 is 0, when the reported code is 2, or when a new pulse for that source arrives in the same cycle.
- R10: status_o follows its inputs with one register stage, and irq_o is set exactly when any of the three valid bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 3 | Critical request pulses for sources 0, 1, 3 |
| main_pend_i | input | 16 | Main source levels (sources 0..3, 5..16) |
| peri_pend_i | input | 31 | Peripheral source levels (sources 1..31) |
| dma_pend_i | input | 1 | DMA summary request (peripheral source 0) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 status/acknowledge, 1 main mask, 2 peripheral mask, 3 unused |
| reg_wdata_i | input | 32 | Register write data |
| status_o | output | 32 | Encoded status word |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a held critical request hidden behind the high-priority cascade. Code 2 is then reported while source 3 is still held, and an acknowledge in that state must not clear source 3. The bench builds this state in order: it first latches a critical pulse, then unmasks one high-priority peripheral and asserts it, then acknowledges. After that it drops the peripheral, and source 3 must reappear. It also makes a pulse and an acknowledge for the same source land in one cycle. Around these directed steps, the bench sweeps pairs of main sources and walking masks in both tiers. It then runs pseudo-random mask and request mixes against an arithmetic model of the three tiers.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int CRIT_N = 4;
  localparam int MAIN_N = 17;
  localparam int PERI_N = 32;
  localparam int CRIT_W = $clog2(CRIT_N);
  localparam int MAIN_W = $clog2(MAIN_N);
  localparam int PERI_W = $clog2(PERI_N);

  localparam int CRIT_VLD = 10;
  localparam int CRIT_LSB = 8;
  localparam int MAIN_VLD = 21;
  localparam int MAIN_LSB = 16;
  localparam int PERI_VLD = 29;
  localparam int PERI_LSB = 24;

  localparam int CRIT_CASC = 2;
  localparam int MAIN_CASC = 4;

  localparam logic [31:0] MAIN_MASK_RST = 32'h0001_0FFF;
  localparam logic [31:0] PERI_MASK_RST = 32'h7FFF_FC00;
  localparam logic [31:0] FIELD_BITS    = 32'h3F3F_0700;

  typedef enum logic [1:0] {
    RA_STAT  = 2'd0,
    RA_MMASK = 2'd1,
    RA_PMASK = 2'd2,
    RA_RSVD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
    vld_o = |req_i;
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_cascade_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [MAIN_N-1:0] main_en_o,
  output logic [PERI_N-1:0] peri_en_o,
  output logic              ack_o
);
  logic [MAIN_N-1:0] main_mask_q;
  logic [PERI_N-1:0] peri_mask_q;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_mask_q <= MAIN_MASK_RST[MAIN_N-1:0];
      peri_mask_q <= PERI_MASK_RST[PERI_N-1:0];
    end else if (we_i) begin
      if (addr == RA_MMASK) main_mask_q <= wdata_i[MAIN_N-1:0];
      if (addr == RA_PMASK) peri_mask_q <= wdata_i[PERI_N-1:0];
    end
  end

  // mask bits are stored msb-first per source; set bit disables
  always_comb begin
    for (int n = 0; n < MAIN_N; n++) main_en_o[n] = ~main_mask_q[MAIN_N-1-n];
    for (int n = 0; n < PERI_N; n++) peri_en_o[n] = ~peri_mask_q[PERI_N-1-n];
  end

  assign ack_o = we_i && (addr == RA_STAT) && wdata_i[CRIT_VLD];
endmodule

// File: rtl/irq_crit_hold.sv
module irq_crit_hold
  import irq_cascade_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        req_i,
  input  logic              ack_i,
  input  logic              ack_vld_i,
  input  logic [CRIT_W-1:0] ack_code_i,
  output logic [2:0]        pend_o
);
  function automatic logic [CRIT_W-1:0] src_of(input int k);
    return (k == 2) ? CRIT_W'(3) : CRIT_W'(k);
  endfunction

  logic [2:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (req_i[k]) pend_q[k] <= 1'b1;
        else if (ack_i && ack_vld_i && ack_code_i == src_of(k)) pend_q[k] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_cascade_enc.sv
module irq_cascade_enc
  import irq_cascade_pkg::*;
#(
  parameter logic [PERI_N-1:0] HP_SET = 32'h0000_00F0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    crit_req_i,
  input  logic [15:0]   main_pend_i,
  input  logic [30:0]   peri_pend_i,
  input  logic          dma_pend_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   status_o,
  output logic          irq_o
);
  logic [MAIN_N-1:0] main_en, main_src, main_act;
  logic [PERI_N-1:0] peri_en, peri_src, peri_act, hp_act;
  logic [CRIT_N-1:0] crit_vec;
  logic [2:0]        crit_pend;
  logic              ack;
  logic              hp_any, lp_any;
  logic              crit_v, main_v, peri_v, hp_v, all_v;
  logic [CRIT_W-1:0] crit_code;
  logic [MAIN_W-1:0] main_code;
  logic [PERI_W-1:0] hp_code, all_code, peri_code;
  logic [31:0]       status_d, status_q;
  logic              irq_q;

  irq_mask_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .main_en_o(main_en), .peri_en_o(peri_en), .ack_o(ack)
  );

  irq_crit_hold u_crit (
    .clk_i, .rst_ni,
    .req_i(crit_req_i), .ack_i(ack),
    .ack_vld_i(status_q[CRIT_VLD]),
    .ack_code_i(status_q[CRIT_LSB +: CRIT_W]),
    .pend_o(crit_pend)
  );

  // peripheral tier
  assign peri_src = {peri_pend_i, dma_pend_i};
  assign peri_act = peri_src & peri_en;
  assign hp_act   = peri_act & HP_SET;
  assign hp_any   = |hp_act;
  assign lp_any   = |(peri_act & ~HP_SET);

  irq_first_set #(.N(PERI_N)) u_hp  (.req_i(hp_act),   .vld_o(hp_v),  .idx_o(hp_code));
  irq_first_set #(.N(PERI_N)) u_all (.req_i(peri_act), .vld_o(all_v), .idx_o(all_code));

  assign peri_v    = all_v;
  assign peri_code = hp_v ? hp_code : all_code;

  // main tier with low-priority cascade slot
  assign main_src = {main_pend_i[15:MAIN_CASC], lp_any, main_pend_i[MAIN_CASC-1:0]};
  assign main_act = main_src & main_en;

  irq_first_set #(.N(MAIN_N)) u_main (.req_i(main_act), .vld_o(main_v), .idx_o(main_code));

  // critical tier with high-priority cascade slot
  assign crit_vec = {crit_pend[2], hp_any, crit_pend[1:0]};

  irq_first_set #(.N(CRIT_N)) u_crit_enc (.req_i(crit_vec), .vld_o(crit_v), .idx_o(crit_code));

  always_comb begin
    status_d = '0;
    status_d[CRIT_VLD]               = crit_v;
    status_d[CRIT_LSB +: CRIT_W]     = crit_code;
    status_d[MAIN_VLD]               = main_v;
    status_d[MAIN_LSB +: MAIN_W]     = main_code;
    status_d[PERI_VLD]               = peri_v;
    status_d[PERI_LSB +: PERI_W]     = peri_code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |crit_vec | |main_act | |peri_act;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter logic [PERI_N-1:0] HP_SET = 32'h0000_00F0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] status_i,
  input logic        irq_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic        ack_bit_i,
  input logic [2:0]  crit_req_i,
  input logic [2:0]  crit_pend_i
);
  logic ack_wr;
  assign ack_wr = we_i && addr_i == 2'd0 && ack_bit_i;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~FIELD_BITS) == 32'h0); // R2
  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_i[CRIT_VLD] |-> status_i[9:8] == 2'd0) and
    (!status_i[MAIN_VLD] |-> status_i[20:16] == 5'd0) and
    (!status_i[PERI_VLD] |-> status_i[28:24] == 5'd0)); // R2
  AST_MAIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[MAIN_VLD] |-> status_i[20:16] <= 5'd16); // R3
  AST_CRIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |crit_req_i |=> (crit_pend_i & $past(crit_req_i)) == $past(crit_req_i)); // R6
  AST_HP_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[CRIT_VLD] && status_i[9:8] == 2'd2) |-> (status_i[PERI_VLD] && HP_SET[status_i[28:24]])); // R7
  AST_LP_CASCADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[MAIN_VLD] && status_i[20:16] == 5'd4) |-> status_i[PERI_VLD]); // R8
  AST_CRIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(crit_pend_i) & ~crit_pend_i) |-> $past(ack_wr)); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (status_i[CRIT_VLD] | status_i[MAIN_VLD] | status_i[PERI_VLD])); // R10
endmodule

bind irq_cascade_enc irq_cascade_chk #(.HP_SET(HP_SET)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_o), .irq_i(irq_o),
  .we_i(reg_we_i), .addr_i(reg_addr_i), .ack_bit_i(reg_wdata_i[10]),
  .crit_req_i(crit_req_i), .crit_pend_i(crit_pend)
);

// File: tb/sim_irq_cascade_enc.sv
`timescale 1ns/1ps
module sim_irq_cascade_enc;
  localparam logic [31:0] HP = 32'h0000_00F0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  crit_req = '0;
  logic [15:0] main_pend = '0;
  logic [30:0] peri_pend = '0;
  logic        dma_pend = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] status;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2:0]  cl = '0;
  logic [31:0] mm, pm, rnd;

  always #4 clk = ~clk;

  irq_cascade_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .crit_req_i(crit_req), .main_pend_i(main_pend),
    .peri_pend_i(peri_pend), .dma_pend_i(dma_pend), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .status_o(status), .irq_o(irq)
  );

  function automatic logic [31:0] model(logic [2:0] c, logic [15:0] mi, logic [30:0] pi,
                                        logic dm, logic [31:0] mmk, logic [31:0] pmk);
    logic [31:0] pact, hp, psel, s;
    logic [16:0] msrc, mact;
    logic [3:0]  cv;
    s = '0;
    for (int n = 0; n < 32; n++) pact[n] = ((n == 0) ? dm : pi[n-1]) & ~pmk[31-n];
    hp   = pact & HP;
    msrc = {mi[15:4], |(pact & ~HP), mi[3:0]};
    for (int n = 0; n < 17; n++) mact[n] = msrc[n] & ~mmk[16-n];
    cv   = {c[2], |hp, c[1], c[0]};
    psel = (|hp) ? hp : pact;
    for (int n = 3; n >= 0; n--) if (cv[n]) begin s[10] = 1'b1; s[9:8] = 2'(n); end
    for (int n = 16; n >= 0; n--) if (mact[n]) begin s[21] = 1'b1; s[20:16] = 5'(n); end
    for (int n = 31; n >= 0; n--) if (psel[n]) begin s[29] = 1'b1; s[28:24] = 5'(n); end
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] exp);
    logic eirq;
    eirq = exp[10] | exp[21] | exp[29];
    checks++;
    if (status !== exp || irq !== eirq) begin
      errors++;
      $display("FAIL %s status=%h irq=%b expected status=%h irq=%b", tag, status, irq, exp, eirq);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(logic [2:0] r);
    @(negedge clk);
    crit_req = r;
    @(posedge clk);
    @(negedge clk);
    crit_req = '0;
    cl = cl | r;
  endtask

  task automatic expect_now(string tag);
    settle();
    chk(tag, model(cl, main_pend, peri_pend, dma_pend, mm, pm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mm = 32'h0001_0FFF; pm = 32'h7FFF_FC00;
    repeat (3) @(negedge clk);
    chk("R1 reset idle", 32'h0);
    rst_n = 1'b1;
    settle();
    chk("R1 idle after release", 32'h0);
    main_pend = '1; peri_pend = '1; dma_pend = 1'b1;
    expect_now("R1 reset masks");
    dma_pend = 1'b0;
    expect_now("R1 reset masks no dma");

    // main pair sweep, peripherals all masked
    main_pend = '0; peri_pend = '0;
    mm = 32'h0; wr(2'd1, mm);
    pm = 32'hFFFF_FFFF; wr(2'd2, pm);
    for (int i = 0; i < 16; i++)
      for (int j = i; j < 16; j++) begin
        main_pend = (16'd1 << i) | (16'd1 << j);
        expect_now("R3 main pair");
      end

    // main walking mask, upper data bits junk
    main_pend = '1;
    for (int k = 0; k <= 17; k++) begin
      mm = (k == 0) ? 32'h0 : (32'h1FFFF & ~((32'h1 << (17 - k)) - 1));
      wr(2'd1, mm | 32'hFFFE_0000);
      expect_now("R4 main mask walk");
    end
    wr(2'd3, 32'h0);
    wr(2'd0, 32'hFFFF_FBFF);
    expect_now("R4 reserved addr and no-ack write");

    // peripheral single-source sweep, main all masked
    main_pend = '0; mm = 32'hFFFF_FFFF; wr(2'd1, mm);
    pm = 32'h0; wr(2'd2, pm);
    for (int n = 0; n < 32; n++) begin
      dma_pend = (n == 0);
      peri_pend = (n == 0) ? 31'h0 : (31'h1 << (n - 1));
      expect_now("R5 peri single");
    end
    peri_pend = '1; dma_pend = 1'b1;
    for (int k = 0; k <= 32; k++) begin
      pm = (k == 0) ? 32'h0 : ~((32'h1 << (32 - k)) - 1);
      if (k == 32) pm = 32'hFFFF_FFFF;
      wr(2'd2, pm);
      expect_now("R5 peri mask walk");
    end

    // cascades with main enabled
    mm = 32'h0; wr(2'd1, mm);
    pm = 32'h0; wr(2'd2, pm);
    peri_pend = 31'h0000_0020; dma_pend = 1'b0;
    expect_now("R7 hp cascade src6");
    peri_pend = 31'h0000_0201;
    expect_now("R8 lp cascade src1,10");
    peri_pend = 31'h0000_0024;
    expect_now("R7 hp beats lower lp");
    mm = 32'h0000_1000; wr(2'd1, mm);
    expect_now("R8 cascade slot masked");

    // pseudo-random mixes
    rnd = 32'h1357_9BDF;
    for (int it = 0; it < 300; it++) begin
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      mm = rnd;
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      pm = rnd | (rnd << 3);
      wr(2'd1, mm); wr(2'd2, pm);
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      main_pend = rnd[15:0] & rnd[31:16];
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      peri_pend = rnd[30:0] & (rnd[31:1] | {rnd[0], rnd[30:1]}); dma_pend = rnd[31];
      expect_now("R3 random mix");
    end

    // critical hold and acknowledge
    main_pend = '0; peri_pend = '0; dma_pend = 1'b0;
    mm = 32'hFFFF_FFFF; wr(2'd1, mm);
    pm = 32'hFFFF_FFFF; wr(2'd2, pm);
    expect_now("R10 quiet");
    pulse(3'b100);
    expect_now("R6 crit src3 held");
    pulse(3'b001);
    expect_now("R6 crit src0 beats src3");
    wr(2'd0, 32'hFFFF_FBFF);
    expect_now("R9 bit10 clear no effect");
    wr(2'd0, 32'h0000_0400); cl[0] = 1'b0;
    expect_now("R9 ack src0");
    pm = 32'hFBFF_FFFF; wr(2'd2, pm);
    peri_pend = 31'h0000_0010;
    expect_now("R7 hp hides src3");
    wr(2'd0, 32'h0000_0400);
    expect_now("R9 ack on code2 keeps src3");
    peri_pend = '0;
    expect_now("R9 src3 reappears");
    pulse(3'b010);
    expect_now("R6 crit src1");
    @(negedge clk);
    we = 1'b1; addr = 2'd0; wdata = 32'h0000_0400; crit_req = 3'b010;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; crit_req = '0;
    expect_now("R9 same-cycle pulse wins");
    wr(2'd0, 32'h0000_0400); cl[1] = 1'b0;
    expect_now("R9 ack src1");
    wr(2'd0, 32'h0000_0400); cl[2] = 1'b0;
    expect_now("R10 all cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule